// File: doc/BRIEF.md
# Edge Time Capture Timer

This block is a free-running timer that stamps the time of external events. A 16-bit count register is widened by an 8-bit prescale extension into a single 24-bit timer. The prescale part is the most significant byte. While enabled, the timer counts up or down without pause. Each qualifying transition of an asynchronous input copies the present timer value into a capture register and raises a sticky event flag. Software clears that flag by writing a one.

A new reload value can be written at any moment. The timer restarts from it on the next cycle, whether or not it is running. The event flag feeds an interrupt output through a mask. The timer does not stop or slow down when a capture happens. A newer event simply replaces an older, unread timestamp.

Top module: `edge_time_capture`

## Requirements
- R1: While `rst` is high, at every clock edge `count_now`, `cap_time`, `evt_raw` and `irq` become zero and the reload value becomes all ones.
- R2: With `en`=1, `count_up`=0 and no load write, each clock edge decrements `count_now` by one. From zero, it moves to the reload value.
- R3: With `en`=1, `count_up`=1 and no load write, each clock edge increments `count_now` by one. When `count_now` is greater than or equal to the reload value, it moves to zero instead.
- R4: With `en`=0 and no load write, `count_now` takes the start value at each edge. The start value is the reload value when counting down and zero when counting up. No capture takes place and `evt_raw` does not get set.
- R5: A clock edge with `load_wr`=1 stores {`prescale`,`load_val`} as the 24-bit reload value, with `prescale` in bits 23:16. At that same edge, `count_now` takes the start value of the new reload value. This applies whether the timer is running or not.
- R6: `cap_in` passes through two synchronizing flops. If a transition is first sampled at edge k, it is acted on at edge k+2. `edge_sel` decides which transitions qualify: 00 none, 01 rising only, 10 falling only, 11 both.
- R7: At the edge where a qualifying transition is acted on with `en`=1, `cap_time` takes the `count_now` value held just before that edge and `evt_raw` is set. The count sequence carries on unchanged.
- R8: `evt_clr`=1 at an edge clears `evt_raw`. If a capture happens at that same edge, the capture wins and `evt_raw` stays set.
- R9: At every edge, `irq` is loaded with the new value of `evt_raw` ANDed with `irq_mask`. `evt_raw` itself does not depend on the mask.
- R10: If a second capture arrives before the flag is cleared, `cap_time` is overwritten with the newer timestamp and `evt_raw` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable for counting and capture |
| count_up | input | 1 | 1 counts up, 0 counts down |
| edge_sel | input | 2 | Qualifying transition select |
| load_val | input | CNT_W | Low part of the reload value |
| prescale | input | PRE_W | High (prescale) part of the reload value |
| load_wr | input | 1 | Write strobe for the reload value |
| irq_mask | input | 1 | Interrupt enable |
| evt_clr | input | 1 | Write-one-to-clear for the event flag |
| cap_in | input | 1 | Asynchronous event input |
| count_now | output | CNT_W+PRE_W | Live timer value |
| cap_time | output | CNT_W+PRE_W | Most recent captured timestamp |
| evt_raw | output | 1 | Sticky capture event flag |
| irq | output | 1 | Masked interrupt |

## Verification
Capture and flag clearing can land on the same clock edge. The same is true for capture and a counter wrap or reload. The bench holds `evt_clr` high across several cycles while `cap_in` toggles, so at least one capture coincides with a clear. It also toggles the input while the timer passes through zero and while a new reload value is written. At every clock, a behavioural model decides whether the set won over the clear, and which pre-edge count the timestamp must carry.

// File: rtl/etc_pkg.sv
package etc_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/etc_sync_edge.sv
module etc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic [1:0] edge_sel,
  output logic       qual
);
  import etc_pkg::*;
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] sq;
  logic              prev;
  edge_mode_e        mode;
  logic              rise_ok, fall_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq   <= '0;
      prev <= 1'b0;
    end else begin
      sq   <= {sq[STAGES-2:0], din};
      prev <= sq[MSB];
    end
  end

  assign mode    = edge_mode_e'(edge_sel);
  assign rise_ok = (mode == EDGE_RISE) || (mode == EDGE_ANY);
  assign fall_ok = (mode == EDGE_FALL) || (mode == EDGE_ANY);

  always_comb begin
    qual = 1'b0;
    if (sq[MSB] != prev)
      qual = sq[MSB] ? rise_ok : fall_ok;
  end
endmodule

// File: rtl/etc_counter.sv
module etc_counter #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          count_up,
  input  logic          load_wr,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] cnt
);
  logic [TW-1:0] ld_q;
  logic [TW-1:0] start_new, start_cur;

  assign start_new = count_up ? '0 : load_val;
  assign start_cur = count_up ? '0 : ld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q <= '1;
      cnt  <= '0;
    end else if (load_wr) begin
      ld_q <= load_val;
      cnt  <= start_new;
    end else if (!en) begin
      cnt  <= start_cur;
    end else if (count_up) begin
      cnt  <= (cnt >= ld_q) ? '0 : cnt + TW'(1);
    end else begin
      cnt  <= (cnt == '0) ? ld_q : cnt - TW'(1);
    end
  end
endmodule

// File: rtl/etc_capture.sv
module etc_capture #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          clr,
  input  logic          mask,
  input  logic [TW-1:0] cnt,
  output logic [TW-1:0] cap,
  output logic          evt,
  output logic          irq
);
  logic evt_nx;

  assign evt_nx = hit | (evt & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap <= '0;
      evt <= 1'b0;
      irq <= 1'b0;
    end else begin
      evt <= evt_nx;
      irq <= evt_nx & mask;
      if (hit) cap <= cnt;
    end
  end
endmodule

// File: rtl/edge_time_capture.sv
module edge_time_capture #(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   count_up,
  input  logic [1:0]             edge_sel,
  input  logic [CNT_W-1:0]       load_val,
  input  logic [PRE_W-1:0]       prescale,
  input  logic                   load_wr,
  input  logic                   irq_mask,
  input  logic                   evt_clr,
  input  logic                   cap_in,
  output logic [CNT_W+PRE_W-1:0] count_now,
  output logic [CNT_W+PRE_W-1:0] cap_time,
  output logic                   evt_raw,
  output logic                   irq
);
  localparam int TW = CNT_W + PRE_W;

  logic [TW-1:0] reload_in;
  logic          qual;
  logic          cap_hit;

  assign reload_in = {prescale, load_val};

  etc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(cap_in), .edge_sel(edge_sel), .qual(qual)
  );

  assign cap_hit = qual & en;

  etc_counter #(.TW(TW)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .count_up(count_up),
    .load_wr(load_wr), .load_val(reload_in), .cnt(count_now)
  );

  etc_capture #(.TW(TW)) u_cap (
    .clk(clk), .rst(rst), .hit(cap_hit), .clr(evt_clr), .mask(irq_mask),
    .cnt(count_now), .cap(cap_time), .evt(evt_raw), .irq(irq)
  );
endmodule

// File: rtl/etc_checker.sv
module etc_checker #(
  parameter int TW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          count_up,
  input logic          load_wr,
  input logic          evt_clr,
  input logic          hit,
  input logic          evt_raw,
  input logic          irq,
  input logic [TW-1:0] count_now,
  input logic [TW-1:0] cap_time
);
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !count_up && !load_wr && count_now != '0) |=> count_now == $past(count_now) - TW'(1)); // R2
  AST_NO_HIT_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |-> !hit); // R4
  AST_EVT_SET: assert property (@(posedge clk) disable iff (rst)
    hit |=> evt_raw); // R7
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (rst)
    hit |=> cap_time == $past(count_now)); // R7
  AST_CAP_KEEP: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(cap_time)); // R7
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (evt_clr && !hit) |=> !evt_raw); // R8
  AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
    irq |-> evt_raw); // R9
endmodule

bind edge_time_capture etc_checker #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .count_up(count_up), .load_wr(load_wr),
  .evt_clr(evt_clr), .hit(cap_hit), .evt_raw(evt_raw), .irq(irq),
  .count_now(count_now), .cap_time(cap_time)
);

// File: tb/edge_time_capture_tb.sv
module edge_time_capture_tb;
  localparam int CLK_P = 10;
  localparam int CNT_W = 16;
  localparam int PRE_W = 8;
  localparam int TW    = CNT_W + PRE_W;

  logic             clk, rst, en, count_up, load_wr, irq_mask, evt_clr, cap_in;
  logic [1:0]       edge_sel;
  logic [CNT_W-1:0] load_val;
  logic [PRE_W-1:0] prescale;
  logic [TW-1:0]    count_now, cap_time;
  logic             evt_raw, irq;

  edge_time_capture #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .count_up(count_up), .edge_sel(edge_sel),
    .load_val(load_val), .prescale(prescale), .load_wr(load_wr),
    .irq_mask(irq_mask), .evt_clr(evt_clr), .cap_in(cap_in),
    .count_now(count_now), .cap_time(cap_time), .evt_raw(evt_raw), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string tag_cnt  = "R2";
  string tag_cap  = "R7";
  string tag_evt  = "R8";

  task automatic chk(input string tag, input string what,
                     input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // behavioural reference model
  bit          m_s1, m_s2, m_s3, m_evt, m_irq, m_hit;
  logic [TW-1:0] m_cnt, m_ld, m_cap;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_cnt = '0; m_ld = '1; m_cap = '0; m_evt = 0; m_irq = 0;
    end else begin
      m_hit = en && (m_s2 != m_s3) &&
              ((m_s2 && edge_sel[0]) || (!m_s2 && edge_sel[1]));
      if (m_hit) m_cap = m_cnt;
      m_evt = m_hit || (m_evt && !evt_clr);
      m_irq = m_evt && irq_mask;
      if (load_wr) begin
        m_ld  = {prescale, load_val};
        m_cnt = count_up ? '0 : m_ld;
      end else if (!en)
        m_cnt = count_up ? '0 : m_ld;
      else if (count_up)
        m_cnt = (m_cnt >= m_ld) ? '0 : m_cnt + 1;
      else
        m_cnt = (m_cnt == 0) ? m_ld : m_cnt - 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
    end
  end

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (!rst) begin
      chk(tag_cnt, "count_now", count_now, m_cnt);
      chk(tag_cap, "cap_time", cap_time, m_cap);
      chk(tag_evt, "evt_raw", TW'(evt_raw), TW'(m_evt));
      chk("R9", "irq", TW'(irq), TW'(m_irq));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle(input int gap, input int times);
    for (int i = 0; i < times; i++) begin
      cap_in = ~cap_in;
      tick(gap);
    end
  endtask

  task automatic load(input logic [PRE_W-1:0] p, input logic [CNT_W-1:0] v);
    prescale = p; load_val = v; load_wr = 1;
    tick(1);
    load_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; en = 0; count_up = 0; load_wr = 0; irq_mask = 0; evt_clr = 0;
    cap_in = 0; edge_sel = 2'b00; load_val = '0; prescale = '0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk("R1", "count_now", count_now, '0);
    chk("R1", "cap_time", cap_time, '0);
    chk("R1", "evt_raw", TW'(evt_raw), '0);
    chk("R1", "irq", TW'(irq), '0);
    @(negedge clk);
    rst = 0;
    tick(2);

    // disabled: hold at start, toggling ignored
    tag_cnt = "R4"; tag_evt = "R4";
    edge_sel = 2'b11;
    load(8'd0, 16'd20);
    toggle(3, 6);
    tick(4);
    chk("R4", "evt_raw while disabled", TW'(evt_raw), '0);

    // down counting with wrap, rising edges only
    tag_cnt = "R2"; tag_cap = "R6"; tag_evt = "R8";
    edge_sel = 2'b01; en = 1;
    toggle(5, 10);
    tick(10);
    evt_clr = 1; tick(1); evt_clr = 0;
    edge_sel = 2'b10;
    toggle(4, 8);
    edge_sel = 2'b00;
    evt_clr = 1; tick(1); evt_clr = 0;
    toggle(3, 6);
    tick(3);
    chk("R6", "evt_raw with no edge selected", TW'(evt_raw), '0);

    // clear held while captures arrive: collision
    tag_cap = "R7"; tag_evt = "R8";
    edge_sel = 2'b11;
    evt_clr = 1;
    toggle(2, 5);
    evt_clr = 0;
    tick(4);

    // interrupt masking
    irq_mask = 1;
    toggle(6, 4);
    evt_clr = 1; tick(2); evt_clr = 0;
    irq_mask = 0;
    toggle(5, 2);
    irq_mask = 1;
    tick(3);

    // reload written while running
    tag_cnt = "R5";
    tick(5);
    load(8'd0, 16'd7);
    toggle(3, 6);
    load(8'd0, 16'd12);
    tick(5);

    // overwrite of an unread timestamp
    tag_cap = "R10";
    evt_clr = 1; tick(1); evt_clr = 0;
    toggle(2, 8);
    chk("R10", "evt_raw after repeated captures", TW'(evt_raw), TW'(1));

    // prescale extension, down count through the high byte
    tag_cnt = "R2"; tag_cap = "R7";
    en = 0;
    load(8'd1, 16'd3);
    en = 1;
    toggle(37, 8);
    tick(20);

    // up counting with wrap
    tag_cnt = "R3";
    en = 0; count_up = 1;
    load(8'd0, 16'd5);
    tick(2);
    en = 1;
    toggle(4, 10);
    tick(10);
    count_up = 0;
    tick(5);

    tick(2);
    finish_run();
  end
endmodule